// File: doc/BRIEF.md
# I-Q impedance demodulator

This block finds the in-phase and quadrature parts of an AC current measured on a device under test. The reference is the AC excitation applied to that device. Each clock cycle it receives one signed current sample from an ADC. In the same cycle it receives the 32-bit phase word of the oscillator that also drives the excitation DAC.

The sample is multiplied by a cosine reference and by a sine reference. Both references come from a quarter-wave table addressed by the phase word. The products are summed over a programmed whole number of reference periods. A window opens and closes only where the phase word wraps, so the component at twice the excitation frequency cancels over the window. Only the DC part remains.

When a window ends, the block presents three results together with a one-cycle completion pulse:

- The in-phase sum, which scales with conductance.
- The quadrature sum, which scales with susceptance.
- The largest current magnitude seen in the window.

Phase angle, impedance magnitude and equivalent-circuit values are computed downstream from these results. A typical use is a 50 mV, 100 kHz excitation on a stepped DC bias, with one window for each bias step.

Top module: `iq_demod`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `i_o`, `q_o`, `peak_o`, `done_o` and `busy_o` are all zero.
- R2: A wrap is a cycle whose `phase_i` is numerically below the previous cycle's `phase_i`. A window opens only in a wrap cycle, and only if a start is pending or `start_i` is high in that cycle. A start that arrives while the block is idle between wraps is held. `busy_o` rises on the cycle after the opening wrap. The opening wrap's sample is the first sample of the window.
- R3: `periods_i` is sampled when a window opens and gives its length N in reference periods; the value 0 is taken as 1. The window closes at the Nth wrap after it opens. The sample at the closing wrap is not part of the window. With a phase step of 2^24, a one-period window keeps `busy_o` high for exactly 256 cycles.
- R4: The reference address is `phase_i[31:22]`. Table entry k (0..255) is T(k) = floor(32767·u·(1024−u) / 2^18), where u = 2k+1. For an address a with quadrant a[9:8] and index a[7:0], sine(a) is:
  - T(index) in quadrant 0;
  - T(255−index) in quadrant 1;
  - −T(index) in quadrant 2;
  - −T(255−index) in quadrant 3.
  
  Cosine(a) is sine((a+256) mod 1024). `i_o` is the signed 48-bit sum of sample×cosine over the window, and `q_o` is the same sum of sample×sine.
- R5: `done_o` is high for exactly the one cycle after a closing wrap. `i_o`, `q_o` and `peak_o` take their new values in that same cycle and hold them at all other times.
- R6: `peak_o` is the largest absolute sample value in the window. A sample of −32768 counts as 32768.
- R7: A start that arrives while a window is running opens the next window at the wrap that closes the current one, so `busy_o` does not drop between the two windows. If no start is pending, `busy_o` falls after the closing wrap.
- R8: With a phase step of 2^24, a window aligned to phase 0 and the current equal to the cosine reference gives `q_o` exactly 0 and a positive `i_o`. With the current equal to the sine reference, the result is `i_o` exactly 0 and a positive `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 32 | Oscillator phase word for this sample |
| samp_i | input | 16 | Signed current sample |
| start_i | input | 1 | Request for one window |
| periods_i | input | 16 | Window length in reference periods (0 means 1) |
| i_o | output | 48 | In-phase sum of the last window |
| q_o | output | 48 | Quadrature sum of the last window |
| peak_o | output | 16 | Peak current magnitude of the last window |
| done_o | output | 1 | One-cycle pulse when results update |
| busy_o | output | 1 | A window is accumulating |

## Verification
One wrap can close a window and open the next one in the same cycle. The results of the old window are latched while the accumulators restart with that wrap's sample. The bench provokes this by pulsing start midway through a running two-period window. It then checks three things at that wrap: `busy_o` stays high across it, the completion pulse carries the old sums, and the next completion carries sums that begin at that wrap's sample. A behavioural model, built from the queued samples of each window, judges the sums, the peak and the busy and done timing on every clock.

// File: rtl/iq_demod.sv
module iq_demod #(
  parameter int PW   = 32,
  parameter int AW   = 10,
  parameter int SW   = 16,
  parameter int TW   = 16,
  parameter int ACCW = 48,
  parameter int NW   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PW-1:0]          phase_i,
  input  logic signed [SW-1:0]   samp_i,
  input  logic                   start_i,
  input  logic [NW-1:0]          periods_i,
  output logic signed [ACCW-1:0] i_o,
  output logic signed [ACCW-1:0] q_o,
  output logic [SW-1:0]          peak_o,
  output logic                   done_o,
  output logic                   busy_o
);
  localparam int QB  = AW - 2;
  localparam int QN  = 2 ** QB;
  localparam int SH  = 2 * AW - 2;
  localparam longint AMP = 2 ** (TW - 1) - 1;

  function automatic logic signed [TW-1:0] qval(input int k);
    longint u, v;
    u = longint'(2 * k + 1);
    v = (AMP * u * (4 * longint'(QN) - u)) >> SH;
    return TW'(v);
  endfunction

  function automatic logic [QB-1:0] qidx(input logic [AW-1:0] a);
    return a[AW-2] ? ~a[QB-1:0] : a[QB-1:0];
  endfunction

  logic signed [TW-1:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_tab
    assign qtab[g] = qval(g);
  end

  logic [AW-1:0] sa, ca;
  logic signed [TW-1:0] sin_m, cos_m, sin_v, cos_v;
  logic signed [SW+TW-1:0] p_i, p_q;
  logic [SW-1:0] mag;

  assign sa    = phase_i[PW-1 -: AW];
  assign ca    = sa + AW'(QN);
  assign sin_m = qtab[qidx(sa)];
  assign cos_m = qtab[qidx(ca)];
  assign sin_v = sa[AW-1] ? -sin_m : sin_m;
  assign cos_v = ca[AW-1] ? -cos_m : cos_m;
  assign p_i   = samp_i * cos_v;
  assign p_q   = samp_i * sin_v;
  assign mag   = samp_i[SW-1] ? SW'(-samp_i) : SW'(samp_i);

  logic [PW-1:0] ph_q;
  logic busy, pend;
  logic [NW-1:0] cnt;
  logic signed [ACCW-1:0] acc_i, acc_q;
  logic [SW-1:0] pk;
  logic wrap, ending, open_w;

  assign wrap   = phase_i < ph_q;
  assign ending = busy && wrap && (cnt == NW'(1));
  assign open_w = wrap && (pend || start_i) && (!busy || ending);
  assign busy_o = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= '0;
      busy   <= 1'b0;
      pend   <= 1'b0;
      cnt    <= '0;
      acc_i  <= '0;
      acc_q  <= '0;
      pk     <= '0;
      i_o    <= '0;
      q_o    <= '0;
      peak_o <= '0;
      done_o <= 1'b0;
    end else begin
      ph_q   <= phase_i;
      done_o <= ending;
      pend   <= (pend || start_i) && !open_w;
      if (ending) begin
        i_o    <= acc_i;
        q_o    <= acc_q;
        peak_o <= pk;
      end
      if (open_w) begin
        busy  <= 1'b1;
        cnt   <= (periods_i == '0) ? NW'(1) : periods_i;
        acc_i <= ACCW'(p_i);
        acc_q <= ACCW'(p_q);
        pk    <= mag;
      end else if (ending) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (wrap) cnt <= cnt - NW'(1);
        acc_i <= acc_i + ACCW'(p_i);
        acc_q <= acc_q + ACCW'(p_q);
        if (mag > pk) pk <= mag;
      end
    end
  end
endmodule

// File: rtl/iq_demod_chk.sv
module iq_demod_chk #(
  parameter int PW   = 32,
  parameter int SW   = 16,
  parameter int ACCW = 48
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [PW-1:0]          phase_i,
  input logic signed [ACCW-1:0] i_o,
  input logic signed [ACCW-1:0] q_o,
  input logic [SW-1:0]          peak_o,
  input logic                   done_o,
  input logic                   busy_o
);
  // R5: completion follows a cycle that was accumulating
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  // R3: a window closes only on a phase wrap
  assert_done_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(phase_i) < $past(phase_i, 2)));

  // R2: a window opens only on a phase wrap
  assert_open_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(phase_i) < $past(phase_i, 2)));

  // R5: results hold between completions
  assert_hold_results_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(i_o) && $stable(q_o) && $stable(peak_o)));

  // R6: peak never exceeds the largest magnitude of a signed sample
  assert_peak_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_o <= SW'(2 ** (SW - 1)));
endmodule

bind iq_demod iq_demod_chk #(.PW(PW), .SW(SW), .ACCW(ACCW)) u_chk (.*);

// File: tb/sim_iq_demod.sv
module sim_iq_demod;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] phase_i = '0;
  logic signed [15:0] samp_i = '0;
  logic start_i = 1'b0;
  logic [15:0] periods_i = 16'd1;
  logic signed [47:0] i_o, q_o;
  logic [15:0] peak_o;
  logic done_o, busy_o;

  iq_demod u0 (.clk(clk), .rst_n(rst_n), .phase_i(phase_i), .samp_i(samp_i),
               .start_i(start_i), .periods_i(periods_i), .i_o(i_o), .q_o(q_o),
               .peak_o(peak_o), .done_o(done_o), .busy_o(busy_o));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint tval(input int k);
    longint u;
    u = 2 * k + 1;
    return (32767 * u * (1024 - u)) / 262144;
  endfunction

  function automatic longint rsin(input int a);
    int q, k;
    longint v;
    q = (a / 256) % 4;
    k = a % 256;
    v = (q % 2 == 1) ? tval(255 - k) : tval(k);
    return (q >= 2) ? -v : v;
  endfunction

  function automatic longint rcos(input int a);
    return rsin((a + 256) % 1024);
  endfunction

  // stimulus source
  logic [31:0] ph = '0, step = '0, lfsr = 32'h1234_5678;
  int mode = 0;
  logic signed [15:0] cval = '0;

  always @(negedge clk) begin
    phase_i = ph;
    case (mode)
      1: samp_i = 16'(rcos(int'(ph[31:22])));
      2: samp_i = 16'(rsin(int'(ph[31:22])));
      3: samp_i = cval;
      default: begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        samp_i = lfsr[15:0];
      end
    endcase
    ph = ph + step;
  end

  // reference model: per-window sample queues
  int qs[$];
  int qa[$];
  logic [31:0] m_prev = '0;
  bit m_busy = 0, m_pend = 0, m_done = 0;
  int m_cnt = 0;
  longint m_i = 0, m_q = 0, m_pk = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = '0; m_busy = 0; m_pend = 0; m_done = 0; m_cnt = 0;
      m_i = 0; m_q = 0; m_pk = 0;
      qs.delete(); qa.delete();
    end else begin
      bit wr;
      wr = phase_i < m_prev;
      m_prev = phase_i;
      m_done = 0;
      if (m_busy && wr) begin
        if (m_cnt == 1) begin
          m_i = 0; m_q = 0; m_pk = 0;
          foreach (qs[n]) begin
            m_i += longint'(qs[n]) * rcos(qa[n]);
            m_q += longint'(qs[n]) * rsin(qa[n]);
            if ((qs[n] < 0 ? -qs[n] : qs[n]) > m_pk) m_pk = (qs[n] < 0) ? -qs[n] : qs[n];
          end
          m_done = 1;
          m_busy = 0;
        end else begin
          m_cnt--;
        end
      end
      if (start_i) m_pend = 1;
      if (wr && !m_busy && m_pend) begin
        m_busy = 1;
        m_pend = 0;
        m_cnt = (periods_i == 0) ? 1 : int'(periods_i);
        qs.delete(); qa.delete();
      end
      if (m_busy) begin
        qs.push_back(int'(samp_i));
        qa.push_back(int'(phase_i[31:22]));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done_o == m_done, "R5 done", longint'(done_o), longint'(m_done));
      chk(busy_o == m_busy, "R2 R3 R7 busy", longint'(busy_o), longint'(m_busy));
      chk(i_o == m_i, "R4 in-phase", longint'(i_o), m_i);
      chk(q_o == m_q, "R4 quadrature", longint'(q_o), m_q);
      chk(longint'(peak_o) == m_pk, "R6 peak", longint'(peak_o), m_pk);
    end
  end

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (done_o) return;
    end
    chk(0, "R5 completion timeout", 0, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nfail++;
      $display("FAIL R5 watchdog actual=%0d expected=finish", cyc);
      finish_run();
    end
  end

  initial begin
    int cnt, dones, idle;
    repeat (5) @(negedge clk);
    chk(i_o == 0, "R1 reset i_o", longint'(i_o), 0);
    chk(q_o == 0, "R1 reset q_o", longint'(q_o), 0);
    chk(peak_o == 0, "R1 reset peak_o", longint'(peak_o), 0);
    chk(!done_o && !busy_o, "R1 reset done/busy", longint'({done_o, busy_o}), 0);
    rst_n = 1'b1;
    step = 32'h0100_0000;
    mode = 1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R1 first cycle", longint'({done_o, busy_o}), 0);

    // R8 cosine current: quadrature cancels
    periods_i = 16'd1;
    pulse_start();
    wait_done();
    chk(q_o == 0, "R8 cos current q_o", longint'(q_o), 0);
    chk(i_o > 0, "R8 cos current i_o positive", longint'(i_o), 1);

    // R8 sine current: in-phase cancels
    mode = 2;
    pulse_start();
    wait_done();
    chk(i_o == 0, "R8 sin current i_o", longint'(i_o), 0);
    chk(q_o > 0, "R8 sin current q_o positive", longint'(q_o), 1);

    // R3 zero periods means one period of 256 cycles
    mode = 0;
    periods_i = 16'd0;
    pulse_start();
    while (!busy_o) @(negedge clk);
    cnt = 0;
    while (busy_o && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 256, "R3 one-period busy length", cnt, 256);

    // R2 start while idle mid-period is held until the wrap
    periods_i = 16'd1;
    while (ph[31:24] != 8'd100) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(!busy_o, "R2 start held until wrap", longint'(busy_o), 0);
    wait_done();

    // R4 random current, odd phase step, three periods
    step = 32'h0123_4567;
    periods_i = 16'd3;
    pulse_start();
    wait_done();
    chk(peak_o != 0, "R4 R6 random window peak", longint'(peak_o), 1);

    // R7 start during a running window chains two windows
    periods_i = 16'd2;
    pulse_start();
    while (!busy_o) @(negedge clk);
    dones = 0; idle = 0;
    for (int n = 0; n < 3000 && dones < 2; n++) begin
      if (n == 100) start_i = 1'b1;
      if (n == 101) start_i = 1'b0;
      @(negedge clk);
      if (done_o) dones++;
      if (dones < 2 && !busy_o) idle++;
    end
    start_i = 1'b0;
    chk(dones == 2, "R7 two completions", dones, 2);
    chk(idle == 0, "R7 busy continuous across windows", idle, 0);
    chk(!busy_o, "R7 idle after last window", longint'(busy_o), 0);

    // R6 most negative sample
    mode = 3;
    cval = -16'sd32768;
    periods_i = 16'd1;
    pulse_start();
    wait_done();
    chk(peak_o == 16'd32768, "R6 peak of -32768", longint'(peak_o), 32768);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule